// File: doc/BRIEF.md
# Speculative Sliced Adder with One-Cycle Recovery

This block is a wide integer add/subtract unit split into equal-width slices that all start at once. Slice 0 takes the true carry-in. Every higher slice guesses its carry-in instead of waiting for the ripple from the slice below. If the top bits of the two operands in the slice below agree, that shared bit settles the carry, whatever comes in underneath it. If they differ, the guess is taken from an externally supplied prediction bit for that slice. Subtraction inverts the second operand and forces the slice-0 carry-in high. The guessing rule then looks at the inverted second-operand bit.

In the evaluation cycle, each slice compares the carry it assumed with the carry the slice below actually produced from its own assumed input. When all slices agree, the result is final one clock later. When any slice disagrees, the unit raises `stall` for that cycle and spends exactly one more cycle on repair. During repair, every slice whose assumed carry differs from the resolved carry chain is recomputed, and the other slices keep their first-pass sums. Along with the exact sum, the unit reports the real inter-slice carries so that an external predictor can update its history. It also reports the per-slice mismatch flags from the first pass.

Top module: `slice_spec_adder`

## Requirements
- R1: With `subOp` low, the final `resSum` equals (`opA` + `opB`) modulo 2^DATA_W, and `resCout` equals the carry out of bit DATA_W-1.
- R2: For slice k ≥ 1 in an addition, if `opA` bit k·SLICE_W-1 equals `opB` bit k·SLICE_W-1, that bit is the guessed carry and `sliceErr[k-1]` is never set for that operation.
- R3: When the R2 bits differ, the guessed carry for slice k is `predCarry[k-1]`. `sliceErr[k-1]` is then set exactly when that bit differs from the first-pass carry out of slice k-1.
- R4: `sliceErr[k-1]` is set when the carry out of slice k-1, computed with slice k-1's own guessed carry-in, differs from the carry guessed by slice k. The flags are presented together with the result.
- R5: An operation with no flag set is accepted on a rising edge, and `resValid` is high for exactly the cycle after the following rising edge.
- R6: `stall` is high during the evaluation cycle of an operation if and only if a flag is set. While `stall` is high, a request on `inValid` is not accepted and waits; it is taken on the next edge after `stall` falls.
- R7: An operation with any flag set produces `resValid` one cycle later than in R5, and its `resSum`, `resCout` and `actCarry` are exact.
- R8: `actCarry[j]` equals the true carry from slice j into slice j+1 of the full-width operation.
- R9: With `subOp` high, `resSum` equals (`opA` − `opB`) modulo 2^DATA_W, computed as `opA` + ~`opB` + 1. `resCout` is the carry out of that sum (1 means no borrow).
- R10: In subtraction, the R2 rule compares `opA` bit k·SLICE_W-1 with the inverted `opB` bit. When those agree, `sliceErr[k-1]` is never set.
- R11: After reset, `stall` and `resValid` are low until an operation is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request: operands are valid this cycle |
| opA | input | DATA_W | First operand |
| opB | input | DATA_W | Second operand |
| subOp | input | 1 | 1 = subtract `opB` from `opA`, 0 = add |
| predCarry | input | NUM_SLICES-1 | Predicted carry-in for slices 1 and up (bit k-1 for slice k) |
| stall | output | 1 | Evaluation found a misprediction; hold the request |
| resValid | output | 1 | Result outputs are final this cycle |
| resSum | output | DATA_W | Exact sum or difference |
| resCout | output | 1 | Carry out of the top slice |
| actCarry | output | NUM_SLICES-1 | Real carry into slice j+1 at bit j |
| sliceErr | output | NUM_SLICES-1 | First-pass mismatch flag for slice j+1 at bit j |

## Verification
The bench builds the unit with 2-bit slices and three slices, which gives a 6-bit datapath. At that size every operand pair, both operations and all four prediction patterns can be swept, about 32 thousand operations. That sweep reaches every combination of static agreement, correct and wrong prediction, and a repaired slice feeding a changed carry into the slice above. A directed sequence holds a second request across a stall to show that it waits and is then taken cleanly.

// File: rtl/spec_add_pkg.sv
package spec_add_pkg;

  // Strobes issued by the sequencing control to the datapath
  typedef struct packed {
    logic loadStage;   // capture new operands into the stage register
    logic evalLive;    // stage holds an operation in its first pass
    logic fixLive;     // stage holds an operation in its repair pass
  } ctrl_strobe_t;

endpackage

// File: rtl/spec_add_slice.sv
module spec_add_slice #(
  parameter int SLICE_W = 8
) (
  input  logic [SLICE_W-1:0] a,
  input  logic [SLICE_W-1:0] b,
  input  logic               sub,
  input  logic               cin,
  output logic [SLICE_W-1:0] sum,
  output logic               cout
);

  logic [SLICE_W-1:0] bEff;
  logic [SLICE_W:0]   total;

  always_comb begin
    bEff  = b ^ {SLICE_W{sub}};
    total = {1'b0, a} + {1'b0, bEff} + {{SLICE_W{1'b0}}, cin};
    sum   = total[SLICE_W-1:0];
    cout  = total[SLICE_W];
  end

endmodule

// File: rtl/spec_add_dp.sv
module spec_add_dp
  import spec_add_pkg::*;
#(
  parameter int SLICE_W    = 8,
  parameter int NUM_SLICES = 8,
  localparam int DATA_W    = SLICE_W * NUM_SLICES,
  localparam int GUESS_W   = NUM_SLICES - 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_strobe_t       strobe,
  input  logic [DATA_W-1:0]  inA,
  input  logic [DATA_W-1:0]  inB,
  input  logic               inSub,
  input  logic [GUESS_W-1:0] inPred,
  output logic               anyErr,
  output logic [DATA_W-1:0]  resSum,
  output logic               resCout,
  output logic [GUESS_W-1:0] resCarry,
  output logic [GUESS_W-1:0] resErr
);

  // Stage register: operands of the operation in flight
  logic [DATA_W-1:0]  opA, opB;
  logic               opSub;
  logic [GUESS_W-1:0] opPred;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opA    <= '0;
      opB    <= '0;
      opSub  <= 1'b0;
      opPred <= '0;
    end else if (strobe.loadStage) begin
      opA    <= inA;
      opB    <= inB;
      opSub  <= inSub;
      opPred <= inPred;
    end
  end

  logic [NUM_SLICES-1:0] specCin, specCout;
  logic [NUM_SLICES-1:0] trueCin, trueCout;
  logic [NUM_SLICES-1:0] redo;
  logic [DATA_W-1:0]     specSum, trueSum;
  logic [GUESS_W-1:0]    errVec;

  for (genvar k = 0; k < NUM_SLICES; k++) begin : gSlice
    if (k == 0) begin : gBase
      assign specCin[k] = opSub;
      assign trueCin[k] = opSub;
    end else begin : gUpper
      logic aTop, bTop, staticOk;
      assign aTop     = opA[k*SLICE_W-1];
      assign bTop     = opB[k*SLICE_W-1] ^ opSub;
      assign staticOk = (aTop == bTop);
      assign specCin[k]  = staticOk ? aTop : opPred[k-1];
      assign trueCin[k]  = trueCout[k-1];
      assign errVec[k-1] = specCout[k-1] != specCin[k];

      // R2 / R10: agreeing top bits fix the carry regardless of what lies below
      assert_static_no_err_R2: assert property (@(posedge clk) disable iff (!rstN)
        (strobe.evalLive && staticOk) |-> !errVec[k-1]);
    end

    // First pass: each slice starts from its guessed carry
    spec_add_slice #(.SLICE_W(SLICE_W)) specSlice_i (
      .a   (opA[k*SLICE_W +: SLICE_W]),
      .b   (opB[k*SLICE_W +: SLICE_W]),
      .sub (opSub),
      .cin (specCin[k]),
      .sum (specSum[k*SLICE_W +: SLICE_W]),
      .cout(specCout[k])
    );

    // Repair pass: slices chained on the resolved carries
    spec_add_slice #(.SLICE_W(SLICE_W)) trueSlice_i (
      .a   (opA[k*SLICE_W +: SLICE_W]),
      .b   (opB[k*SLICE_W +: SLICE_W]),
      .sub (opSub),
      .cin (trueCin[k]),
      .sum (trueSum[k*SLICE_W +: SLICE_W]),
      .cout(trueCout[k])
    );

    assign redo[k] = trueCin[k] != specCin[k];
  end

  assign anyErr = |errVec;

  // Repaired slices take the resolved sum, the rest keep the first-pass sum
  logic [DATA_W-1:0] mergedSum;
  always_comb begin
    mergedSum = resSum;
    for (int k = 0; k < NUM_SLICES; k++) begin
      if (redo[k]) mergedSum[k*SLICE_W +: SLICE_W] = trueSum[k*SLICE_W +: SLICE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resSum   <= '0;
      resCout  <= 1'b0;
      resCarry <= '0;
      resErr   <= '0;
    end else if (strobe.evalLive) begin
      resSum   <= specSum;
      resCout  <= specCout[NUM_SLICES-1];
      resCarry <= specCout[NUM_SLICES-2:0];
      resErr   <= errVec;
    end else if (strobe.fixLive) begin
      resSum   <= mergedSum;
      resCout  <= trueCout[NUM_SLICES-1];
      resCarry <= trueCin[NUM_SLICES-1:1];
    end
  end

  // R8: a clean first pass means every guessed carry was the real one
  assert_clean_carries_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.evalLive && !anyErr) |-> (specCin == trueCin));

  // R7: the repair pass always touches at least one slice when it runs
  assert_fix_has_work_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fixLive |-> (redo != '0 || resErr != '0));

endmodule

// File: rtl/spec_add_ctrl.sv
module spec_add_ctrl
  import spec_add_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         anyErr,
  output ctrl_strobe_t strobe,
  output logic         stall,
  output logic         resValid
);

  logic evalV, fixV;

  assign stall            = evalV && anyErr;
  assign strobe.loadStage = inValid && !stall;
  assign strobe.evalLive  = evalV;
  assign strobe.fixLive   = fixV;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evalV    <= 1'b0;
      fixV     <= 1'b0;
      resValid <= 1'b0;
    end else begin
      evalV    <= strobe.loadStage;
      fixV     <= evalV && anyErr;
      resValid <= (evalV && !anyErr) || fixV;
    end
  end

  assert_err_then_fix_R7: assert property (@(posedge clk) disable iff (!rstN)
    (evalV && anyErr) |=> (fixV && !resValid));

  assert_fix_then_valid_R7: assert property (@(posedge clk) disable iff (!rstN)
    fixV |=> resValid);

  assert_clean_valid_R5: assert property (@(posedge clk) disable iff (!rstN)
    (evalV && !anyErr) |=> (resValid && !fixV));

  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({evalV, fixV}));

endmodule

// File: rtl/slice_spec_adder.sv
module slice_spec_adder
  import spec_add_pkg::*;
#(
  parameter int SLICE_W    = 8,
  parameter int NUM_SLICES = 8,
  localparam int DATA_W    = SLICE_W * NUM_SLICES,
  localparam int GUESS_W   = NUM_SLICES - 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [DATA_W-1:0]  opA,
  input  logic [DATA_W-1:0]  opB,
  input  logic               subOp,
  input  logic [GUESS_W-1:0] predCarry,
  output logic               stall,
  output logic               resValid,
  output logic [DATA_W-1:0]  resSum,
  output logic               resCout,
  output logic [GUESS_W-1:0] actCarry,
  output logic [GUESS_W-1:0] sliceErr
);

  ctrl_strobe_t strobe;
  logic         anyErr;

  spec_add_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .anyErr  (anyErr),
    .strobe  (strobe),
    .stall   (stall),
    .resValid(resValid)
  );

  spec_add_dp #(.SLICE_W(SLICE_W), .NUM_SLICES(NUM_SLICES)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .inA     (opA),
    .inB     (opB),
    .inSub   (subOp),
    .inPred  (predCarry),
    .anyErr  (anyErr),
    .resSum  (resSum),
    .resCout (resCout),
    .resCarry(actCarry),
    .resErr  (sliceErr)
  );

  // R11: nothing is reported before an operation has been taken
  assert_reset_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resValid) |-> $past(strobe.evalLive || strobe.fixLive));

endmodule

// File: tb/slice_spec_adder_tb_top.sv
module slice_spec_adder_tb_top;

  localparam int W    = 2;
  localparam int N    = 3;
  localparam int DW   = W * N;
  localparam int MASK = (1 << DW) - 1;
  localparam int SM   = (1 << W) - 1;

  logic          clk = 1'b0;
  logic          rstN;
  logic          inValid;
  logic [DW-1:0] opA, opB;
  logic          subOp;
  logic [N-2:0]  predCarry;
  logic          stall, resValid, resCout;
  logic [DW-1:0] resSum;
  logic [N-2:0]  actCarry, sliceErr;

  int  nTests = 0;
  int  nFail  = 0;
  bit  done   = 0;

  always #4 clk = ~clk;

  slice_spec_adder #(.SLICE_W(W), .NUM_SLICES(N)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .subOp(subOp), .predCarry(predCarry), .stall(stall), .resValid(resValid),
    .resSum(resSum), .resCout(resCout), .actCarry(actCarry), .sliceErr(sliceErr)
  );

  task automatic check(input int act, input int exp, input string tag);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Expected values derived from the requirements
  function automatic void calc(input int a, input int b, input int s, input int p,
                               output int eSum, output int eCout, output int eCar,
                               output int eErr, output int eStatic);
    int bx, tot;
    int spec [N];
    bx = (s != 0) ? (~b & MASK) : b;
    tot = a + bx + s;
    eSum = tot & MASK;
    eCout = tot >> DW;
    eCar = 0; eErr = 0; eStatic = 0;
    spec[0] = s;
    for (int k = 1; k < N; k++) begin
      int lowM, at, bt, tc, sc;
      lowM = (1 << (k * W)) - 1;
      tc = ((a & lowM) + (bx & lowM) + s) >> (k * W);
      eCar |= tc << (k - 1);
      at = (a >> (k * W - 1)) & 1;
      bt = (bx >> (k * W - 1)) & 1;
      if (at == bt) begin
        spec[k] = at;
        eStatic |= 1 << (k - 1);
      end else begin
        spec[k] = (p >> (k - 1)) & 1;
      end
      sc = (((a >> ((k - 1) * W)) & SM) + ((bx >> ((k - 1) * W)) & SM) + spec[k - 1]) >> W;
      if (sc != spec[k]) eErr |= 1 << (k - 1);
    end
  endfunction

  task automatic checkResult(input int s, input int eSum, input int eCout,
                             input int eCar, input int eErr, input int eStatic);
    check(int'(resValid), 1, (eErr != 0) ? "R7 resValid after repair" : "R5 resValid");
    check(int'(resSum), eSum, (s != 0) ? "R9 difference" : "R1 sum");
    check(int'(resCout), eCout, (s != 0) ? "R9 carry out" : "R1 carry out");
    check(int'(actCarry), eCar, "R8 actual carries");
    check(int'(sliceErr), eErr, "R4 slice flags");
    for (int k = 0; k < N - 1; k++) begin
      if (((eStatic >> k) & 1) != 0)
        check(int'(sliceErr[k]), 0, (s != 0) ? "R10 static slice" : "R2 static slice");
      else
        check(int'(sliceErr[k]), (eErr >> k) & 1, "R3 predicted slice");
    end
  endtask

  // Starts and ends at a falling edge
  task automatic runOp(input int a, input int b, input int s, input int p);
    int eSum, eCout, eCar, eErr, eStatic;
    calc(a, b, s, p, eSum, eCout, eCar, eErr, eStatic);
    opA = DW'(a); opB = DW'(b); subOp = s[0]; predCarry = (N-1)'(p);
    inValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    check(int'(stall), (eErr != 0) ? 1 : 0, "R6 stall in evaluation");
    @(negedge clk);
    if (eErr != 0) begin
      check(int'(resValid), 0, "R7 no result before repair");
      @(negedge clk);
    end
    checkResult(s, eSum, eCout, eCar, eErr, eStatic);
  endtask

  initial begin
    for (int c = 0; c < 190000 && !done; c++) @(posedge clk);
    if (!done) begin
      nFail++;
      nTests++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    int eSum, eCout, eCar, eErr, eStatic;
    rstN = 1'b0; inValid = 1'b0; opA = '0; opB = '0; subOp = 1'b0; predCarry = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(int'(stall), 0, "R11 stall after reset");
    check(int'(resValid), 0, "R11 resValid after reset");

    // Directed: a second request is held across a stall (R6)
    opA = 6'd3; opB = 6'd1; subOp = 1'b0; predCarry = '0; inValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    opA = 6'd5; opB = 6'd2; predCarry = '0;
    check(int'(stall), 1, "R6 stall on mispredict");
    @(negedge clk);
    check(int'(stall), 0, "R6 stall released");
    check(int'(resValid), 0, "R7 repair cycle");
    @(negedge clk);
    inValid = 1'b0;
    calc(3, 1, 0, 0, eSum, eCout, eCar, eErr, eStatic);
    checkResult(0, eSum, eCout, eCar, eErr, eStatic);
    check(int'(stall), 0, "R6 held request evaluates clean");
    @(negedge clk);
    calc(5, 2, 0, 0, eSum, eCout, eCar, eErr, eStatic);
    checkResult(0, eSum, eCout, eCar, eErr, eStatic);

    // Exhaustive sweep
    for (int s = 0; s < 2; s++)
      for (int p = 0; p < (1 << (N - 1)); p++)
        for (int a = 0; a <= MASK; a++)
          for (int b = 0; b <= MASK; b++)
            runOp(a, b, s, p);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule